// File: doc/BRIEF.md
# Subchannel engine binding dispatcher

This block sits between a command-stream front end and a set of five execution engines. Each incoming call carries a method number, a 32-bit argument, a 3-bit subchannel and a remaining-call count. The block keeps a small table that says which engine class each subchannel is currently bound to, and steers every ordinary call to the handshake port of that engine. The fields of the call are passed on unchanged, so an engine can still tell the last call of a burst from its count (1 or less means last).

The table is programmed in-band. A call whose method number is the reserved bind method (0) is not forwarded. Its argument, cut to a 16-bit class code, is written into the table entry of the call's subchannel. A call that reaches a subchannel bound to a code matching none of the five supported classes is accepted and dropped. It raises a sticky error flag and records that subchannel. The table is visible on a flat debug output.

Only one call is ever in flight. The input handshake is combinationally tied to the ready of the selected engine, so the front end stalls until that engine takes the call.

Top module: `subch_dispatch`

## Requirements
- R1: After reset all 8 table entries hold the invalid code 16'h0000, the error flag is 0 and no engine valid is raised while no call is offered.
- R2: A valid call with method 0 is accepted in the same cycle (in_ready=1) and raises no engine valid. From the next cycle the entry of its subchannel holds the low 16 bits of its argument.
- R3: A valid call with any other method raises exactly the one engine valid bit whose class code equals the entry of its subchannel: bit 0 for 2D (16'h902D), bit 1 for 3D (16'hB197), bit 2 for compute (16'hB1C0), bit 3 for DMA copy (16'hB0B5), bit 4 for inline-to-memory (16'hA140).
- R4: While an engine valid is raised, the shared outputs carry the call's method, argument, subchannel and count unchanged.
- R5: For a forwarded call, in_ready equals the ready of the selected engine, so the call stalls while that engine is not ready.
- R6: A valid non-bind call on a subchannel whose entry matches no class is accepted with no engine valid. From the next cycle the error flag is 1 and the error subchannel holds that call's subchannel. Both keep their values until reset, so later faults do not change them.
- R7: The table entry of a subchannel is written only by a bind call on that subchannel. The table output packs entry i at bits [16*i+15:16*i].
- R8: Argument bits 31..16 of a bind call have no effect on the stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A call is offered |
| in_ready | output | 1 | The offered call is taken this cycle |
| in_method | input | 13 | Method number of the call |
| in_arg | input | 32 | Argument of the call |
| in_subch | input | 3 | Subchannel of the call |
| in_count | input | 24 | Remaining-call count |
| eng_valid | output | 5 | One valid per engine class |
| eng_ready | input | 5 | One ready per engine class |
| out_method | output | 13 | Forwarded method number |
| out_arg | output | 32 | Forwarded argument |
| out_subch | output | 3 | Forwarded subchannel |
| out_count | output | 24 | Forwarded count |
| bind_table | output | 128 | All table entries, entry i at [16*i+15:16*i] |
| err_flag | output | 1 | Sticky unknown-engine flag |
| err_subch | output | 3 | Subchannel of the first unknown-engine call |

## Verification
The hardest state to reach is a forwarded call that is stalled on a subchannel whose binding changed only a cycle earlier. The stall must follow the newly bound engine's ready and not the old one's. Random traffic reaches this by issuing binds on about a quarter of cycles. Bind arguments are drawn mostly from the five class codes with random upper bits, and each engine's ready is toggled at random every cycle. Subchannels are drawn from all eight, so back-to-back rebinds of the same entry occur. Directed calls cover an unknown code on subchannel 7 and a bind whose upper argument bits are all ones.

// File: rtl/subch_dispatch_pkg.sv
package subch_dispatch_pkg;
  localparam int ENG_N = 5;
  typedef enum logic [2:0] {
    ENG_2D   = 3'd0,
    ENG_3D   = 3'd1,
    ENG_COMP = 3'd2,
    ENG_DMA  = 3'd3,
    ENG_I2M  = 3'd4
  } eng_e;
endpackage

// File: rtl/sd_bind_table.sv
module sd_bind_table #(
  parameter int          SUB_W    = 3,
  parameter int          ID_W     = 16,
  parameter logic [15:0] RESET_ID = 16'h0000,
  localparam int         SUB_N    = 1 << SUB_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SUB_W-1:0]      wr_idx,
  input  logic [ID_W-1:0]       wr_id,
  input  logic [SUB_W-1:0]      rd_idx,
  output logic [ID_W-1:0]       rd_id,
  output logic [SUB_N*ID_W-1:0] table_flat
);
  logic [ID_W-1:0] ent_q [SUB_N];

  for (genvar i = 0; i < SUB_N; i++) begin : g_ent
    logic [ID_W-1:0] ent_nxt;
    logic            ent_en;
    always_comb begin
      ent_en  = wr_en && (wr_idx == SUB_W'(i));
      ent_nxt = wr_id;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= ID_W'(RESET_ID);
      else if (ent_en) ent_q[i] <= ent_nxt;
    end
    assign table_flat[i*ID_W +: ID_W] = ent_q[i];
  end

  assign rd_id = ent_q[rd_idx];
endmodule

// File: rtl/sd_engine_decode.sv
module sd_engine_decode
  import subch_dispatch_pkg::*;
#(
  parameter int                    ID_W  = 16,
  parameter logic [ENG_N*16-1:0]   CODES = '0
) (
  input  logic [ID_W-1:0]  id,
  output logic [ENG_N-1:0] hit,
  output logic             known
);
  for (genvar k = 0; k < ENG_N; k++) begin : g_cmp
    assign hit[k] = (id == ID_W'(CODES[k*16 +: 16]));
  end
  assign known = |hit;
endmodule

// File: rtl/sd_fault_latch.sv
module sd_fault_latch #(
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [SUB_W-1:0] set_sub,
  output logic             err,
  output logic [SUB_W-1:0] err_sub
);
  logic             err_nxt;
  logic [SUB_W-1:0] sub_nxt;
  logic             cap_en;

  always_comb begin
    cap_en  = set && !err;
    err_nxt = 1'b1;
    sub_nxt = set_sub;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err     <= 1'b0;
      err_sub <= '0;
    end else if (cap_en) begin
      err     <= err_nxt;
      err_sub <= sub_nxt;
    end
  end
endmodule

// File: rtl/subch_dispatch.sv
module subch_dispatch
  import subch_dispatch_pkg::*;
#(
  parameter int          METHOD_W    = 13,
  parameter int          ARG_W       = 32,
  parameter int          SUBCH_W     = 3,
  parameter int          CNT_W       = 24,
  parameter int          ID_W        = 16,
  parameter int          BIND_METHOD = 0,
  parameter logic [15:0] ID_NONE     = 16'h0000,
  parameter logic [15:0] ID_2D       = 16'h902D,
  parameter logic [15:0] ID_3D       = 16'hB197,
  parameter logic [15:0] ID_COMP     = 16'hB1C0,
  parameter logic [15:0] ID_DMA      = 16'hB0B5,
  parameter logic [15:0] ID_I2M      = 16'hA140
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [METHOD_W-1:0]           in_method,
  input  logic [ARG_W-1:0]              in_arg,
  input  logic [SUBCH_W-1:0]            in_subch,
  input  logic [CNT_W-1:0]              in_count,
  output logic [4:0]                    eng_valid,
  input  logic [4:0]                    eng_ready,
  output logic [METHOD_W-1:0]           out_method,
  output logic [ARG_W-1:0]              out_arg,
  output logic [SUBCH_W-1:0]            out_subch,
  output logic [CNT_W-1:0]              out_count,
  output logic [(ID_W<<SUBCH_W)-1:0]    bind_table,
  output logic                          err_flag,
  output logic [SUBCH_W-1:0]            err_subch
);
  localparam int                  SUB_N = 1 << SUBCH_W;
  localparam logic [ENG_N*16-1:0] CODES = {ID_I2M, ID_DMA, ID_COMP, ID_3D, ID_2D};

  logic             is_bind;
  logic [ID_W-1:0]  cur_id;
  logic [ENG_N-1:0] hit;
  logic             known;
  logic             bind_we;
  logic             fault_set;

  always_comb begin
    is_bind   = (in_method == METHOD_W'(BIND_METHOD));
    eng_valid = (in_valid && !is_bind) ? hit : '0;
    in_ready  = is_bind || !known || |(hit & eng_ready);
    bind_we   = in_valid && in_ready && is_bind;
    fault_set = in_valid && !is_bind && !known;
  end

  sd_bind_table #(.SUB_W(SUBCH_W), .ID_W(ID_W), .RESET_ID(ID_NONE)) table_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bind_we),
    .wr_idx     (in_subch),
    .wr_id      (in_arg[ID_W-1:0]),
    .rd_idx     (in_subch),
    .rd_id      (cur_id),
    .table_flat (bind_table)
  );

  sd_engine_decode #(.ID_W(ID_W), .CODES(CODES)) decode_i (
    .id    (cur_id),
    .hit   (hit),
    .known (known)
  );

  sd_fault_latch #(.SUB_W(SUBCH_W)) fault_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (fault_set),
    .set_sub (in_subch),
    .err     (err_flag),
    .err_sub (err_subch)
  );

  assign out_method = in_method;
  assign out_arg    = in_arg;
  assign out_subch  = in_subch;
  assign out_count  = in_count;

  if (SUB_N < 2) begin : g_param_chk
    initial $error("subch_dispatch: at least two subchannels needed");
  end
endmodule

// File: rtl/subch_dispatch_chk.sv
module subch_dispatch_chk #(
  parameter int METHOD_W = 13,
  parameter int ARG_W    = 32,
  parameter int SUBCH_W  = 3,
  parameter int ID_W     = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [METHOD_W-1:0]        in_method,
  input logic [ARG_W-1:0]           in_arg,
  input logic [SUBCH_W-1:0]         in_subch,
  input logic [4:0]                 eng_valid,
  input logic [4:0]                 eng_ready,
  input logic [(ID_W<<SUBCH_W)-1:0] bind_table,
  input logic                       err_flag,
  input logic [SUBCH_W-1:0]         err_subch
);
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid));

  assert_bind_nofwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_method == '0) |-> (eng_valid == '0 && in_ready));

  assert_bind_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_method == '0) |=>
      (bind_table[$past(in_subch)*ID_W +: ID_W] == $past(in_arg[ID_W-1:0])));

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eng_valid & ~eng_ready)) |-> !in_ready);

  assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eng_valid & eng_ready)) |-> in_ready);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (err_flag && $stable(err_subch)));

  assert_unknown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_method != '0 && eng_valid == '0) |=> err_flag);
endmodule

bind subch_dispatch subch_dispatch_chk #(
  .METHOD_W(METHOD_W), .ARG_W(ARG_W), .SUBCH_W(SUBCH_W), .ID_W(ID_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_method(in_method), .in_arg(in_arg), .in_subch(in_subch),
  .eng_valid(eng_valid), .eng_ready(eng_ready), .bind_table(bind_table),
  .err_flag(err_flag), .err_subch(err_subch)
);

// File: tb/subch_dispatch_tb.sv
module subch_dispatch_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [12:0]  in_method = '0;
  logic [31:0]  in_arg = '0;
  logic [2:0]   in_subch = '0;
  logic [23:0]  in_count = '0;
  logic [4:0]   eng_valid;
  logic [4:0]   eng_ready = '0;
  logic [12:0]  out_method;
  logic [31:0]  out_arg;
  logic [2:0]   out_subch;
  logic [23:0]  out_count;
  logic [127:0] bind_table;
  logic         err_flag;
  logic [2:0]   err_subch;

  subch_dispatch dut_i (.*);

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] codes [6] = '{16'h902D, 16'hB197, 16'hB1C0, 16'hB0B5, 16'hA140, 16'h1234};
  logic [15:0] m_tab [8];
  bit          m_err;
  logic [2:0]  m_err_sub;

  function automatic int exp_idx(logic [15:0] id);
    for (int k = 0; k < 5; k++) if (id == codes[k]) return k;
    return 5;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [12:0] m, logic [31:0] a, logic [2:0] s, logic [23:0] c,
                      bit v, logic [4:0] rdy);
    int  k;
    logic [4:0] ev;
    bit  er;
    logic [127:0] tab;
    @(negedge clk);
    in_method = m; in_arg = a; in_subch = s; in_count = c; in_valid = v; eng_ready = rdy;
    #5;
    for (int i = 0; i < 8; i++) tab[i*16 +: 16] = m_tab[i];
    chk(bind_table == tab, "R7 table", bind_table, tab);
    chk(err_flag == m_err, "R6 err_flag", err_flag, m_err);
    if (m_err) chk(err_subch == m_err_sub, "R6 err_subch", err_subch, m_err_sub);
    k  = exp_idx(m_tab[s]);
    ev = (v && m != 0 && k < 5) ? 5'(1 << k) : 5'd0;
    er = (m == 0) || (k == 5) || rdy[k];
    chk(eng_valid == ev, "R3 eng_valid", eng_valid, ev);
    if (v && m != 0 && k < 5)
      chk(in_ready == er, "R5 in_ready", in_ready, er);
    else if (v)
      chk(in_ready == 1'b1, (m == 0) ? "R2 in_ready" : "R6 in_ready", in_ready, 1);
    if (ev != 0)
      chk({out_method, out_arg, out_subch, out_count} == {m, a, s, c}, "R4 fields",
          {out_method, out_arg, out_subch, out_count}, {m, a, s, c});
    if (v && er) begin
      if (m == 0) m_tab[s] = a[15:0];
      else if (k == 5 && !m_err) begin m_err = 1'b1; m_err_sub = s; end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m_tab[i] = 16'h0000;
    m_err = 1'b0; m_err_sub = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    #2;
    chk(bind_table == '0, "R1 table", bind_table, 0);
    chk(err_flag == 1'b0, "R1 err", err_flag, 0);
    chk(eng_valid == '0, "R1 eng_valid", eng_valid, 0);
    // directed: bind 3D to subch 1, stall then accept (R5)
    step(13'd0, {16'hABCD, 16'hB197}, 3'd1, 24'd1, 1'b1, 5'b00000);
    step(13'h55, 32'hDEAD_BEEF, 3'd1, 24'd3, 1'b1, 5'b11101);
    step(13'h55, 32'hDEAD_BEEF, 3'd1, 24'd3, 1'b1, 5'b00010);
    // R8: upper bits ignored on bind
    step(13'd0, 32'hFFFF_B0B5, 3'd2, 24'd0, 1'b1, 5'b00000);
    step(13'd0, 32'd0, 3'd0, 24'd0, 1'b0, 5'b00000);
    chk(bind_table[47:32] == 16'hB0B5, "R8 entry", bind_table[47:32], 16'hB0B5);
    // R6: unknown engine on subch 7, then a second fault on subch 0
    step(13'h10, 32'h1, 3'd7, 24'd1, 1'b1, 5'b11111);
    step(13'h10, 32'h1, 3'd0, 24'd1, 1'b1, 5'b11111);
    step(13'd0, 32'd0, 3'd0, 24'd0, 1'b0, 5'b00000);
    chk(err_subch == 3'd7, "R6 first fault kept", err_subch, 7);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [12:0] m;
      logic [31:0] a;
      m = ($urandom % 4 == 0) ? 13'd0 : 13'($urandom);
      a = (m == 0) ? {16'($urandom), codes[$urandom % 6]} : $urandom;
      step(m, a, 3'($urandom), 24'($urandom % 4), ($urandom % 5) != 0, 5'($urandom));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule